// File: doc/BRIEF.md
# Dataway List-Mode Command Sequencer

This block runs a stored list of dataway commands in list order. Each list entry names a station, a subaddress and a function code. The sequencer reads the entries one by one from a local command memory through that memory's read port. For each entry it runs one dataway cycle. When the function is a read, it stores the returned word in an output buffer. Entries may address any module in any order. The run ends after the last entry. It can end earlier when an addressed module fails to answer, or when the host allows an attention request to halt the list.

The block overlaps fetch and execution. The next entry is fetched while the current dataway cycle is running. As a result, the only idle slot in a run is the single fetch-latency clock before the first cycle, and all later cycles follow back to back. Attention requests are ignored while the list runs. The exception is when the halt-on-attention input is set: an attention request then ends the list once the cycle in progress has finished. The outcome is reported with a two-bit status code and a stop index. Loading the list memory and the electrical dataway layer belong to other blocks. The parameter `CYC_CLKS` must be at least 2.

Top module: `lms_list_seq`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `dw_active`, `dw_strobe`, `buf_we` and `cmd_rd_en` are 0 and `stat` is 0.
- R2: A list entry is a 14-bit word: bits 13:9 are the station, bits 8:5 the subaddress and bits 4:0 the function. Entry i drives `dw_n`, `dw_a` and `dw_f` for the i-th dataway cycle of the run, in list order.
- R3: A start with a nonzero length gives exactly one busy clock before the first dataway cycle. Each cycle is `CYC_CLKS` clocks long with `dw_strobe` on its last clock. Cycles follow each other with no idle clock, so a run that executes n entries is busy for 1 + n*`CYC_CLKS` clocks.
- R4: A function code below 8 is a read. A read that completes with `dw_x` high writes `dw_rdata`, sampled at the strobe edge, to the buffer one clock later. Buffer addresses run 0, 1, 2, ... within a run. Functions of 8 and above write nothing.
- R5: After the strobe of the last entry, `done` is high for exactly one clock, `busy` falls, `stat` is 0 and `stop_idx` equals the list length.
- R6: A start with list length 0 raises `done` for one clock with `stat` 0 and `stop_idx` 0. No dataway cycle and no fetch happen.
- R7: When `dw_x` is low at a strobe, the run stops after that cycle with `stat` 1 and `stop_idx` set to that entry's index. No buffer write is made for that entry and no later entry is executed.
- R8: With `halt_on_lam` low, `lam` has no effect and the full list runs.
- R9: With `halt_on_lam` high, a `lam` seen during a cycle ends the run after that cycle, with `stat` 2 and `stop_idx` equal to the number of entries completed. If that cycle was the last entry, the run ends normally with `stat` 0.
- R10: A start pulse while `busy` is high is ignored. The list length is captured at the accepted start.
- R11: Each fetch asserts `cmd_rd_en` with `cmd_addr` for one clock, and data is expected one clock later. Entries are fetched once each, in order from 0. A run that executes n entries of a length-L list makes 1 + min(n, L-1) fetches.
- R12: A `list_len` above `DEPTH` is treated as `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| list_len | input | LEN_W | Number of list entries to run |
| halt_on_lam | input | 1 | Allow an attention request to end the list |
| lam | input | 1 | Attention request from the modules |
| cmd_rd_en | output | 1 | Command memory read enable |
| cmd_addr | output | ADDR_W | Command memory read address |
| cmd_rdata | input | 14 | Command memory read data, one clock after the enable |
| dw_active | output | 1 | A dataway cycle is in progress |
| dw_strobe | output | 1 | Last clock of a cycle; responses are sampled at its end |
| dw_n | output | 5 | Station number |
| dw_a | output | 4 | Subaddress |
| dw_f | output | 5 | Function code |
| dw_x | input | 1 | Command-accepted response |
| dw_rdata | input | DATA_W | Read data from the dataway |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | ADDR_W | Buffer write address |
| buf_wdata | output | DATA_W | Buffer write data |
| busy | output | 1 | A list is running |
| done | output | 1 | One-clock pulse at the end of a run |
| stat | output | 2 | 0 completed, 1 missing response, 2 halted on attention |
| stop_idx | output | LEN_W | Index at which the run ended |

## Verification
The bench targets the edges of a run. It covers an empty list, a single entry, a full list, a length above the memory depth, a missing response on the first entry and on the last, an attention request on a middle entry and on the last, and a start pulse in the middle of a run. A design that gets these wrong behaves visibly:
- An off-by-one end test runs one extra entry or stops one early.
- A prefetch that is not cancelled on an early stop leaves a stale entry, which shows up as a wrong command on the next run.
- A failing read that is still buffered shows up as an extra buffer word.
- A start that is not blocked while busy restarts the list.

Cycle counts of busy clocks catch a second fetch bubble or an idle clock between cycles. Random lists with mixed read and write functions check the buffer address sequence and the data against a model in the bench.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int CMD_W = 14;

  // Packed list entry: station in the top bits, function in the low bits.
  typedef struct packed {
    logic [4:0] stn;
    logic [3:0] sub;
    logic [4:0] fn;
  } lms_cmd_t;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_NOX = 2'd1,
    ST_LAM = 2'd2
  } lms_stat_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PRIME = 2'd1,
    SQ_RUN   = 2'd2
  } lms_state_e;

  function automatic logic fn_is_read(input logic [4:0] fn);
    return fn < 5'd8;
  endfunction
endpackage

// File: rtl/lms_fetch.sv
// Command fetch unit: issues reads, tracks the one outstanding word and
// holds a prefetched entry until the sequencer consumes it.
module lms_fetch #(
  parameter int ADDR_W = 4,
  parameter int CMD_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              consume,
  input  logic              flush,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [CMD_W-1:0]  rd_data,
  output logic              nxt_vld,
  output logic [CMD_W-1:0]  nxt_cmd
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              infl_q, infl_d;
  logic [CMD_W-1:0]  hold_q, hold_d;
  logic              hvld_q, hvld_d;

  assign rd_en   = issue;
  assign rd_addr = ptr_q;
  assign nxt_vld = hvld_q | infl_q;
  assign nxt_cmd = hvld_q ? hold_q : rd_data;

  always_comb begin
    ptr_d  = ptr_q;
    infl_d = issue;
    hold_d = hold_q;
    hvld_d = hvld_q;
    if (issue) ptr_d = ptr_q + 1'b1;
    if (flush) begin
      ptr_d  = '0;
      infl_d = 1'b0;
      hvld_d = 1'b0;
    end else if (consume) begin
      hvld_d = 1'b0;
    end else if (infl_q) begin
      hold_d = rd_data;
      hvld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      infl_q <= 1'b0;
      hold_q <= '0;
      hvld_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      infl_q <= infl_d;
      if (infl_q && !consume) hold_q <= hold_d;
      hvld_q <= hvld_d;
    end
  end
endmodule

// File: rtl/lms_cyc_timer.sv
// Dataway cycle timer: counts clocks of each cycle and flags the last one.
module lms_cyc_timer #(
  parameter int CYC_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CYC_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == CNT_END);

  always_comb begin
    cnt_d = '0;
    if (run && !last) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lms_buf_wr.sv
// Output buffer writer: registers one word per accepted read.
module lms_buf_wr #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata
);
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    wptr_d = wptr_q;
    if (clear)       wptr_d = '0;
    else if (wr_req) wptr_d = wptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      we_q   <= wr_req;
      if (wr_req) begin
        addr_q <= wptr_q;
        data_q <= wr_data;
      end
    end
  end

  assign buf_we    = we_q;
  assign buf_addr  = addr_q;
  assign buf_wdata = data_q;
endmodule

// File: rtl/lms_list_seq.sv
module lms_list_seq
  import lms_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 24,
  parameter int CYC_CLKS = 4,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int LEN_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  list_len,
  input  logic              halt_on_lam,
  input  logic              lam,
  output logic              cmd_rd_en,
  output logic [ADDR_W-1:0] cmd_addr,
  input  logic [13:0]       cmd_rdata,
  output logic              dw_active,
  output logic              dw_strobe,
  output logic [4:0]        dw_n,
  output logic [3:0]        dw_a,
  output logic [4:0]        dw_f,
  input  logic              dw_x,
  input  logic [DATA_W-1:0] dw_rdata,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        stat,
  output logic [LEN_W-1:0]  stop_idx
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DEPTH);

  lms_state_e        state_q, state_d;
  logic [LEN_W-1:0]  idx_q, idx_d;
  logic [LEN_W-1:0]  len_q, len_d;
  lms_cmd_t          cur_q, cur_d;
  logic              lamp_q, lamp_d;
  logic              done_q, done_d;
  lms_stat_e         stat_q, stat_d;
  logic [LEN_W-1:0]  sidx_q, sidx_d;

  logic              f_issue, f_consume, f_flush, f_nvld;
  logic [CMD_W-1:0]  f_ncmd;
  logic              t_last;
  logic              start_ok;
  logic [LEN_W-1:0]  len_cl;
  logic [LEN_W:0]    idx_p1, idx_p2;
  logic              last_ent, lam_hit, adv, stop;

  lms_fetch #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (f_issue),
    .consume (f_consume),
    .flush   (f_flush),
    .rd_en   (cmd_rd_en),
    .rd_addr (cmd_addr),
    .rd_data (cmd_rdata),
    .nxt_vld (f_nvld),
    .nxt_cmd (f_ncmd)
  );

  lms_cyc_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == SQ_RUN),
    .last  (t_last)
  );

  lms_buf_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bufwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_ok),
    .wr_req    (t_last && dw_x && fn_is_read(cur_q.fn)),
    .wr_data   (dw_rdata),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata)
  );

  // Decision terms for the current cycle.
  always_comb begin
    start_ok  = (state_q == SQ_IDLE) && start;
    len_cl    = (list_len > LEN_MAX) ? LEN_MAX : list_len;
    idx_p1    = {1'b0, idx_q} + 1'b1;
    idx_p2    = {1'b0, idx_q} + 2'd2;
    last_ent  = (idx_p1 == {1'b0, len_q});
    lam_hit   = halt_on_lam && (lamp_q || lam);
    adv       = t_last && dw_x && !last_ent && !lam_hit;
    stop      = t_last && (!dw_x || last_ent || lam_hit);
    f_flush   = stop;
    f_consume = ((state_q == SQ_PRIME) && f_nvld) || adv;
    f_issue   = (start_ok && (len_cl != '0))
             || ((state_q == SQ_PRIME) && f_nvld && (len_q > LEN_W'(1)))
             || (adv && (idx_p2 < {1'b0, len_q}));
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    len_d   = len_q;
    cur_d   = cur_q;
    lamp_d  = lamp_q;
    done_d  = 1'b0;
    stat_d  = stat_q;
    sidx_d  = sidx_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_ok) begin
          len_d  = len_cl;
          idx_d  = '0;
          lamp_d = 1'b0;
          if (len_cl == '0) begin
            done_d = 1'b1;
            stat_d = ST_OK;
            sidx_d = '0;
          end else begin
            state_d = SQ_PRIME;
          end
        end
      end
      SQ_PRIME: begin
        if (halt_on_lam && lam) lamp_d = 1'b1;
        if (f_nvld) begin
          cur_d   = lms_cmd_t'(f_ncmd);
          state_d = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (halt_on_lam && lam) lamp_d = 1'b1;
        if (stop) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
          if (!dw_x) begin
            stat_d = ST_NOX;
            sidx_d = idx_q;
          end else if (last_ent) begin
            stat_d = ST_OK;
            sidx_d = len_q;
          end else begin
            stat_d = ST_LAM;
            sidx_d = idx_p1[LEN_W-1:0];
          end
        end else if (adv) begin
          idx_d = idx_p1[LEN_W-1:0];
          cur_d = lms_cmd_t'(f_ncmd);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      cur_q   <= '0;
      lamp_q  <= 1'b0;
      done_q  <= 1'b0;
      stat_q  <= ST_OK;
      sidx_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      cur_q   <= cur_d;
      lamp_q  <= lamp_d;
      done_q  <= done_d;
      stat_q  <= stat_d;
      sidx_q  <= sidx_d;
    end
  end

  assign dw_active = (state_q == SQ_RUN);
  assign dw_strobe = t_last;
  assign dw_n      = cur_q.stn;
  assign dw_a      = cur_q.sub;
  assign dw_f      = cur_q.fn;
  assign busy      = (state_q != SQ_IDLE);
  assign done      = done_q;
  assign stat      = stat_q;
  assign stop_idx  = sidx_q;
endmodule

// File: rtl/lms_list_seq_chk.sv
module lms_list_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] stat,
  input logic       dw_active,
  input logic       dw_strobe,
  input logic       dw_x,
  input logic [4:0] dw_n,
  input logic [3:0] dw_a,
  input logic [4:0] dw_f,
  input logic       buf_we,
  input logic       cmd_rd_en
);
  p_strobe_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dw_strobe |-> dw_active);

  p_cycle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_active && !dw_strobe) |=> (dw_active && $stable({dw_n, dw_a, dw_f})));

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ($past(dw_strobe) && $past(dw_x) && ($past(dw_f) < 5'd8)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !dw_active));

  p_nox_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_strobe && !dw_x) |=> (done && !dw_active && !buf_we && stat == 2'd1));

  p_fetch_when_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd_en |-> (busy || start));
endmodule

bind lms_list_seq lms_list_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .stat      (stat),
  .dw_active (dw_active),
  .dw_strobe (dw_strobe),
  .dw_x      (dw_x),
  .dw_n      (dw_n),
  .dw_a      (dw_a),
  .dw_f      (dw_f),
  .buf_we    (buf_we),
  .cmd_rd_en (cmd_rd_en)
);

// File: tb/lms_list_seq_bench.sv
module lms_list_seq_bench;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 24;
  localparam int CYC    = 4;
  localparam int ADDR_W = 4;
  localparam int LEN_W  = 5;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic              start, halt_on_lam, lam, cmd_rd_en, dw_active, dw_strobe, dw_x;
  logic [LEN_W-1:0]  list_len, stop_idx;
  logic [ADDR_W-1:0] cmd_addr, buf_addr;
  logic [13:0]       cmd_rdata;
  logic [4:0]        dw_n, dw_f;
  logic [3:0]        dw_a;
  logic [DATA_W-1:0] dw_rdata, buf_wdata;
  logic              buf_we, busy, done;
  logic [1:0]        stat;

  lms_list_seq #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CYC_CLKS(CYC)) u_lms_list_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .list_len(list_len),
    .halt_on_lam(halt_on_lam), .lam(lam),
    .cmd_rd_en(cmd_rd_en), .cmd_addr(cmd_addr), .cmd_rdata(cmd_rdata),
    .dw_active(dw_active), .dw_strobe(dw_strobe), .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f),
    .dw_x(dw_x), .dw_rdata(dw_rdata),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .busy(busy), .done(done), .stat(stat), .stop_idx(stop_idx)
  );

  // Bench-side command memory and dataway responder.
  logic [13:0]       cmd_mem [DEPTH];
  logic [DEPTH-1:0]  x_ok;
  logic [9:0]        salt;
  int                seen;
  int                lam_at;
  logic              lam_cfg;

  always @(posedge clk) if (cmd_rd_en) cmd_rdata <= cmd_mem[cmd_addr];
  assign dw_rdata = {salt, dw_n, dw_a, dw_f};
  assign dw_x     = (seen < DEPTH) ? x_ok[seen] : 1'b1;
  assign lam      = lam_cfg && dw_active && (seen == lam_at);

  // Monitor, sampling at the falling edge.
  logic mon_clr;
  logic prev_strobe;
  int n_strobe, n_wr, n_fetch, n_busy, n_gap, n_done;
  logic [13:0]       got_cmd [DEPTH];
  logic [ADDR_W-1:0] got_waddr [DEPTH];
  logic [DATA_W-1:0] got_wdata [DEPTH];
  logic [ADDR_W-1:0] got_faddr [DEPTH];

  initial begin
    seen = 0; prev_strobe = 1'b0;
    n_strobe = 0; n_wr = 0; n_fetch = 0; n_busy = 0; n_gap = 0; n_done = 0;
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      seen = 0; n_strobe = 0; n_wr = 0; n_fetch = 0; n_busy = 0; n_gap = 0; n_done = 0;
      prev_strobe = 1'b0;
    end else if (prev_strobe) begin
      seen = seen + 1;
    end
    prev_strobe = dw_strobe;
    if (dw_strobe) begin
      if (n_strobe < DEPTH) got_cmd[n_strobe] = {dw_n, dw_a, dw_f};
      n_strobe++;
    end
    if (buf_we) begin
      if (n_wr < DEPTH) begin got_waddr[n_wr] = buf_addr; got_wdata[n_wr] = buf_wdata; end
      n_wr++;
    end
    if (cmd_rd_en) begin
      if (n_fetch < DEPTH) got_faddr[n_fetch] = cmd_addr;
      n_fetch++;
    end
    if (busy) n_busy++;
    if (busy && !dw_active) n_gap++;
    if (done) n_done++;
  end

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill_list(input int fail_pct);
    for (int i = 0; i < DEPTH; i++) begin
      cmd_mem[i] = 14'($urandom);
      x_ok[i]    = ($urandom_range(0, 99) >= fail_pct);
    end
    salt = 10'($urandom);
  endtask

  task automatic run_list(input int len, input bit halt, input int lam_idx,
                          input bit poke_mid, input string tag);
    int eff, n_exec, e_stat, e_stop, e_rd, e_fetch, k;
    logic [DATA_W-1:0] e_data [DEPTH];
    eff = (len > DEPTH) ? DEPTH : len;
    n_exec = 0; e_stat = 0; e_stop = eff; e_rd = 0;
    for (int i = 0; i < eff; i++) begin
      n_exec = i + 1;
      if (!x_ok[i]) begin e_stat = 1; e_stop = i; break; end
      if (cmd_mem[i][4:0] < 5'd8) begin e_data[e_rd] = {salt, cmd_mem[i]}; e_rd++; end
      if (i == eff - 1) break;
      if (halt && i == lam_idx) begin e_stat = 2; e_stop = i + 1; break; end
    end
    e_fetch = (eff == 0) ? 0 : 1 + ((n_exec < eff - 1) ? n_exec : eff - 1);

    @(posedge clk); #5;
    list_len = LEN_W'(len); halt_on_lam = halt; lam_cfg = (lam_idx >= 0); lam_at = lam_idx;
    start = 1'b1; mon_clr = 1'b1;
    @(posedge clk); #5;
    start = 1'b0; mon_clr = 1'b0;
    k = 0;
    while (n_done == 0 && k < 3000) begin
      @(posedge clk); #5;
      k++;
      if (poke_mid && k == 3) begin start = 1'b1; list_len = LEN_W'(1); end
      else begin start = 1'b0; list_len = LEN_W'(len); end
    end
    start = 1'b0;
    check(k < 3000, "R5", {tag, " run ends"}, k, 0);
    repeat (4) @(posedge clk);
    #5;

    check(n_strobe == n_exec, (poke_mid ? "R10" : "R3"), {tag, " cycles run"}, n_strobe, n_exec);
    for (int i = 0; i < n_exec && i < n_strobe; i++)
      check(got_cmd[i] == cmd_mem[i], "R2", {tag, " command order"}, got_cmd[i], cmd_mem[i]);
    check(n_wr == e_rd, "R4", {tag, " buffer writes"}, n_wr, e_rd);
    for (int i = 0; i < e_rd && i < n_wr; i++) begin
      check(got_waddr[i] == ADDR_W'(i), "R4", {tag, " buffer address"}, got_waddr[i], i);
      check(got_wdata[i] == e_data[i], "R4", {tag, " buffer data"}, got_wdata[i], e_data[i]);
    end
    check(n_done == 1, (eff == 0) ? "R6" : "R5", {tag, " done pulse"}, n_done, 1);
    check(stat == 2'(e_stat), (e_stat == 1) ? "R7" : (halt ? "R9" : "R8"), {tag, " status"}, stat, e_stat);
    check(stop_idx == LEN_W'(e_stop), (e_stat == 1) ? "R7" : ((len > DEPTH) ? "R12" : "R9"),
          {tag, " stop index"}, stop_idx, e_stop);
    check(n_busy == ((eff == 0) ? 0 : 1 + n_exec * CYC), "R3", {tag, " busy clocks"},
          n_busy, (eff == 0) ? 0 : 1 + n_exec * CYC);
    check(n_gap == ((eff == 0) ? 0 : 1), "R3", {tag, " idle clocks"}, n_gap, (eff == 0) ? 0 : 1);
    check(n_fetch == e_fetch, "R11", {tag, " fetch count"}, n_fetch, e_fetch);
    for (int i = 0; i < e_fetch && i < n_fetch; i++)
      check(got_faddr[i] == ADDR_W'(i), "R11", {tag, " fetch address"}, got_faddr[i], i);
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL R5 watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 1'b0; start = 1'b0; list_len = '0; halt_on_lam = 1'b0;
    lam_cfg = 1'b0; lam_at = -1; mon_clr = 1'b0; salt = '0; x_ok = '1;
    for (int i = 0; i < DEPTH; i++) cmd_mem[i] = '0;
    repeat (3) @(posedge clk);
    #5;
    check(!busy && !done && !dw_active && !dw_strobe && !buf_we && !cmd_rd_en && stat == 2'd0,
          "R1", "outputs in reset", {busy, done, dw_active, buf_we, cmd_rd_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    check(!busy && !done && !dw_active && !buf_we && !cmd_rd_en && stat == 2'd0,
          "R1", "outputs after reset", {busy, done, dw_active, buf_we, cmd_rd_en}, 0);

    // Directed corner cases.
    fill_list(0);
    run_list(0, 1'b0, -1, 1'b0, "R6 empty list");
    run_list(1, 1'b0, -1, 1'b0, "single entry");
    run_list(DEPTH, 1'b0, -1, 1'b0, "full list");
    run_list(DEPTH + 7, 1'b0, -1, 1'b0, "R12 length clamp");
    x_ok[0] = 1'b0;
    run_list(6, 1'b0, -1, 1'b0, "R7 first entry no response");
    x_ok[0] = 1'b1; x_ok[5] = 1'b0;
    run_list(6, 1'b0, -1, 1'b0, "R7 last entry no response");
    x_ok[5] = 1'b1;
    run_list(8, 1'b1, 2, 1'b0, "R9 halt mid list");
    run_list(5, 1'b1, 4, 1'b0, "R9 halt on last entry");
    run_list(8, 1'b0, 2, 1'b0, "R8 request ignored");
    run_list(7, 1'b0, -1, 1'b1, "R10 start while busy");
    run_list(3, 1'b1, 0, 1'b0, "R9 halt on first entry");

    // Random lists.
    for (int r = 0; r < 40; r++) begin
      int len, lidx;
      bit hl;
      fill_list(8);
      len  = $urandom_range(0, DEPTH + 2);
      hl   = $urandom_range(0, 1);
      lidx = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, DEPTH - 1);
      run_list(len, hl, lidx, 1'b0, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule